// File: doc/BRIEF.md
# Programmable associative row decoder

This block is the row-select stage of a memory bank in which no physical row has a fixed address. Every physical decoder row holds a logical row tag that can be rewritten at run time. A lookup finds the row whose stored tag equals the incoming address, in the way a cache compares tags. A logical row can therefore move to any physical row, and a worn-out row can be taken out of service, while software keeps using the same logical address.

Decoding has two levels. A global directory holds one logical subarray tag per physical subarray and compares it against the upper address bits. Inside each subarray, a row bank holds one logical row tag per physical row and compares it against the lower address bits. A row is selected only when both levels match. A single row and a whole subarray can each be remapped on their own. A program port writes or clears either kind of tag. A fault port retires a physical row and moves its tag to an empty, healthy row in the same subarray.

A lookup takes one clock: the select vector, hit and miss appear in the cycle after the request. Program errors appear on the same cycle as the lookup result, and so does the exhausted flag. The memory array and its data path are not part of this block.

Top module: `assoc_row_decoder`

## Requirements
- R1: After reset and until a program request is accepted, sel_o is all zeros and hit_o, miss_o, prog_err_o and spare_exhausted_o are 0. A lookup then misses because no subarray or row is valid.
- R2: One cycle after a lookup, hit_o is 1 and sel_o has exactly bit p set when logical address A matches both levels. Here p = s*ROWS_PER_SUB + r. Physical subarray s must be valid with tag A[LADDR_W-1:ROW_TAG_W], and its row r must be valid and not failed with tag A[ROW_TAG_W-1:0].
- R3: One cycle after a lookup that matches no row, miss_o is 1, hit_o is 0 and sel_o is all zeros. This includes an address whose subarray tag matches but whose row tag does not.
- R4: A row write (prog_op_i = 2'b00) stores prog_addr_i[ROW_TAG_W-1:0] into physical row prog_phys_i and marks the row valid. The same row may be rewritten, including with the tag it already holds, and the new tag is then the only one that selects it.
- R5: A row write is rejected with prog_err_o = 1 one cycle later, and with no change to the mapping, in two cases: another valid row of the same subarray already holds the tag, or the target row has failed.
- R6: A row invalidate (prog_op_i = 2'b01) clears the valid bit of row prog_phys_i, and its tag no longer matches.
- R7: A subarray write (prog_op_i = 2'b10) stores prog_addr_i[LADDR_W-1:ROW_TAG_W] as the tag of physical subarray prog_phys_i[PIDX_W-1:RIDX_W] and marks it valid. The write is rejected with prog_err_o = 1 when another valid subarray already holds that tag.
- R8: A subarray invalidate (prog_op_i = 2'b11) removes a physical subarray from matching. The logical subarray tag can then be given to another physical subarray, and lookups reach that subarray's rows.
- R9: A fault request on row f marks f failed and removes it from matching. If f held a valid tag, the tag is copied into the lowest-numbered row of the same subarray that is neither valid nor failed, so the same logical address then selects that row.
- R10: A fault request for which the subarray has no empty, healthy row other than f sets spare_exhausted_o one cycle later. The flag stays set until reset.
- R11: A program request made in the same cycle as a fault request is not applied and gives prog_err_o = 1 one cycle later.
- R12: In a cycle after no lookup, hit_o and miss_o are 0 and sel_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | LADDR_W | Logical address to look up (subarray tag in the upper bits) |
| sel_o | output | PHYS_ROWS | One-hot physical row select, registered |
| hit_o | output | 1 | Previous lookup matched a row |
| miss_o | output | 1 | Previous lookup matched no row |
| prog_valid_i | input | 1 | Program request |
| prog_op_i | input | 2 | 00 row write, 01 row invalidate, 10 subarray write, 11 subarray invalidate |
| prog_phys_i | input | PIDX_W | Physical row index; the upper SIDX_W bits name the subarray |
| prog_addr_i | input | LADDR_W | Tag source: lower bits for row ops, upper bits for subarray ops |
| prog_err_o | output | 1 | One-cycle pulse: previous program request was rejected |
| flt_valid_i | input | 1 | Fault request |
| flt_phys_i | input | PIDX_W | Physical row to retire |
| spare_exhausted_o | output | 1 | Sticky: a fault found no spare row |

## Verification
The checker treats lk_valid_i, prog_valid_i and flt_valid_i as one-cycle qualifiers that the bench drives on the falling edge. It also assumes that index inputs never name a row beyond PHYS_ROWS, which holds because the default geometry is a power of two. The one-hot and miss properties depend on the decoder itself refusing duplicate tags. To exercise that refusal, the stimulus deliberately tries to place duplicate tags, and every request is issued on its own so that the result of each one can be attributed. The one exception is the directed clash test for R11, which raises a program request and a fault request in the same cycle.

// File: rtl/ard_pkg.sv
`timescale 1ns/1ps
package ard_pkg;
   typedef enum logic [1:0] {
      OP_ROW_WR  = 2'b00,
      OP_ROW_INV = 2'b01,
      OP_SUB_WR  = 2'b10,
      OP_SUB_INV = 2'b11
   } ard_op_e;
endpackage

// File: rtl/ard_row_bank.sv
`timescale 1ns/1ps
// Row tag store and local matcher for one physical subarray.
module ard_row_bank #(
   parameter int unsigned ROWS      = 8,
   parameter int unsigned TAG_W     = 4,
   parameter bit          PICK_HIGH = 1'b0,
   localparam int unsigned IDX_W    = $clog2(ROWS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [TAG_W-1:0] lk_tag_i,
   output logic [ROWS-1:0]  match_o,
   input  logic [IDX_W-1:0] wr_row_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic             wr_en_i,
   input  logic             inv_en_i,
   output logic             dup_o,
   output logic             tgt_failed_o,
   input  logic             flt_en_i,
   input  logic [IDX_W-1:0] flt_row_i,
   output logic             spare_none_o
);
   logic [TAG_W-1:0] tag_q [ROWS];
   logic [ROWS-1:0]  valid_q, failed_q;
   logic [ROWS-1:0]  live, dup_vec, spare_vec;
   logic [IDX_W-1:0] spare_idx;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign live[r]      = valid_q[r] & ~failed_q[r];
      assign match_o[r]   = live[r] && (tag_q[r] == lk_tag_i);
      assign dup_vec[r]   = live[r] && (tag_q[r] == wr_tag_i) && (IDX_W'(r) != wr_row_i);
      assign spare_vec[r] = ~valid_q[r] && ~failed_q[r] && (IDX_W'(r) != flt_row_i);
   end

   assign dup_o        = |dup_vec;
   assign tgt_failed_o = failed_q[wr_row_i];
   assign spare_none_o = ~|spare_vec;

   // Spare selection policy.
   if (PICK_HIGH) begin : g_pick_high
      always_comb begin
         spare_idx = '0;
         for (int i = 0; i < ROWS; i++)
            if (spare_vec[i]) spare_idx = IDX_W'(i);
      end
   end else begin : g_pick_low
      always_comb begin
         spare_idx = '0;
         for (int i = ROWS - 1; i >= 0; i--)
            if (spare_vec[i]) spare_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q  <= '0;
         failed_q <= '0;
         for (int i = 0; i < ROWS; i++) tag_q[i] <= '0;
      end else if (flt_en_i) begin
         failed_q[flt_row_i] <= 1'b1;
         valid_q[flt_row_i]  <= 1'b0;
         if (valid_q[flt_row_i] && !spare_none_o) begin
            tag_q[spare_idx]   <= tag_q[flt_row_i];
            valid_q[spare_idx] <= 1'b1;
         end
      end else if (wr_en_i) begin
         tag_q[wr_row_i]   <= wr_tag_i;
         valid_q[wr_row_i] <= 1'b1;
      end else if (inv_en_i) begin
         valid_q[wr_row_i] <= 1'b0;
      end
   end
endmodule

// File: rtl/ard_sub_dir.sv
`timescale 1ns/1ps
// Global stage: logical subarray tag per physical subarray.
module ard_sub_dir #(
   parameter int unsigned SUBS  = 4,
   parameter int unsigned TAG_W = 3,
   localparam int unsigned IDX_W = $clog2(SUBS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [TAG_W-1:0] lk_tag_i,
   output logic [SUBS-1:0]  match_o,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic             wr_en_i,
   input  logic             inv_en_i,
   output logic             dup_o
);
   logic [TAG_W-1:0] tag_q [SUBS];
   logic [SUBS-1:0]  valid_q, dup_vec;

   for (genvar s = 0; s < SUBS; s++) begin : g_sub
      assign match_o[s] = valid_q[s] && (tag_q[s] == lk_tag_i);
      assign dup_vec[s] = valid_q[s] && (tag_q[s] == wr_tag_i) && (IDX_W'(s) != wr_idx_i);
   end
   assign dup_o = |dup_vec;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= '0;
         for (int i = 0; i < SUBS; i++) tag_q[i] <= '0;
      end else if (wr_en_i) begin
         tag_q[wr_idx_i]   <= wr_tag_i;
         valid_q[wr_idx_i] <= 1'b1;
      end else if (inv_en_i) begin
         valid_q[wr_idx_i] <= 1'b0;
      end
   end
endmodule

// File: rtl/assoc_row_decoder.sv
`timescale 1ns/1ps
module assoc_row_decoder
   import ard_pkg::*;
#(
   parameter int unsigned SUB_CNT      = 4,
   parameter int unsigned ROWS_PER_SUB = 8,
   parameter int unsigned SUB_TAG_W    = 3,
   parameter int unsigned ROW_TAG_W    = 4,
   parameter bit          SPARE_HIGH   = 1'b0,
   localparam int unsigned SIDX_W    = $clog2(SUB_CNT),
   localparam int unsigned RIDX_W    = $clog2(ROWS_PER_SUB),
   localparam int unsigned PIDX_W    = SIDX_W + RIDX_W,
   localparam int unsigned LADDR_W   = SUB_TAG_W + ROW_TAG_W,
   localparam int unsigned PHYS_ROWS = SUB_CNT * ROWS_PER_SUB
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 lk_valid_i,
   input  logic [LADDR_W-1:0]   lk_addr_i,
   output logic [PHYS_ROWS-1:0] sel_o,
   output logic                 hit_o,
   output logic                 miss_o,
   input  logic                 prog_valid_i,
   input  logic [1:0]           prog_op_i,
   input  logic [PIDX_W-1:0]    prog_phys_i,
   input  logic [LADDR_W-1:0]   prog_addr_i,
   output logic                 prog_err_o,
   input  logic                 flt_valid_i,
   input  logic [PIDX_W-1:0]    flt_phys_i,
   output logic                 spare_exhausted_o
);
   // Elaboration-time parameter checks.
   if (SUB_CNT < 2 || (SUB_CNT & (SUB_CNT - 1)) != 0) begin : g_bad_subs
      $error("SUB_CNT must be a power of two of at least 2");
   end
   if (ROWS_PER_SUB < 2 || (ROWS_PER_SUB & (ROWS_PER_SUB - 1)) != 0) begin : g_bad_rows
      $error("ROWS_PER_SUB must be a power of two of at least 2");
   end
   if ((1 << SUB_TAG_W) < SUB_CNT) begin : g_bad_stag
      $error("SUB_TAG_W too narrow to give every subarray its own tag");
   end
   if ((1 << ROW_TAG_W) < ROWS_PER_SUB) begin : g_bad_rtag
      $error("ROW_TAG_W too narrow to give every row its own tag");
   end

   // Field split of the request buses.
   logic [SUB_TAG_W-1:0] lk_sub_tag, pg_sub_tag;
   logic [ROW_TAG_W-1:0] lk_row_tag, pg_row_tag;
   logic [SIDX_W-1:0]    pg_sidx, fl_sidx;
   logic [RIDX_W-1:0]    pg_ridx, fl_ridx;

   assign lk_sub_tag = lk_addr_i[LADDR_W-1 -: SUB_TAG_W];
   assign lk_row_tag = lk_addr_i[ROW_TAG_W-1:0];
   assign pg_sub_tag = prog_addr_i[LADDR_W-1 -: SUB_TAG_W];
   assign pg_row_tag = prog_addr_i[ROW_TAG_W-1:0];
   assign pg_sidx    = prog_phys_i[PIDX_W-1 -: SIDX_W];
   assign pg_ridx    = prog_phys_i[RIDX_W-1:0];
   assign fl_sidx    = flt_phys_i[PIDX_W-1 -: SIDX_W];
   assign fl_ridx    = flt_phys_i[RIDX_W-1:0];

   // Request decode and rejection.
   ard_op_e op;
   logic    row_wr_req, row_inv_req, sub_wr_req, sub_inv_req;
   logic    row_wr_ok, row_inv_ok, sub_wr_ok, sub_inv_ok;
   logic    row_reject, sub_reject, err_d;
   logic    dir_dup, dup_sel, tfail_sel, snone_sel;

   always_comb begin
      op          = ard_op_e'(prog_op_i);
      row_wr_req  = prog_valid_i && (op == OP_ROW_WR);
      row_inv_req = prog_valid_i && (op == OP_ROW_INV);
      sub_wr_req  = prog_valid_i && (op == OP_SUB_WR);
      sub_inv_req = prog_valid_i && (op == OP_SUB_INV);
      row_reject  = row_wr_req && (dup_sel || tfail_sel);
      sub_reject  = sub_wr_req && dir_dup;
      err_d       = prog_valid_i && (flt_valid_i || row_reject || sub_reject);
      row_wr_ok   = row_wr_req  && !row_reject && !flt_valid_i;
      row_inv_ok  = row_inv_req && !flt_valid_i;
      sub_wr_ok   = sub_wr_req  && !sub_reject && !flt_valid_i;
      sub_inv_ok  = sub_inv_req && !flt_valid_i;
   end

   // Global stage.
   logic [SUB_CNT-1:0] sub_match;

   ard_sub_dir #(.SUBS(SUB_CNT), .TAG_W(SUB_TAG_W)) u_dir (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lk_tag_i (lk_sub_tag),
      .match_o  (sub_match),
      .wr_idx_i (pg_sidx),
      .wr_tag_i (pg_sub_tag),
      .wr_en_i  (sub_wr_ok),
      .inv_en_i (sub_inv_ok),
      .dup_o    (dir_dup)
   );

   // Local stage: one row bank per physical subarray.
   logic [ROWS_PER_SUB-1:0] bank_match [SUB_CNT];
   logic [SUB_CNT-1:0]      bank_dup, bank_tfail, bank_snone;
   logic [PHYS_ROWS-1:0]    sel_d;

   for (genvar s = 0; s < SUB_CNT; s++) begin : g_bank
      logic wr_en_s, inv_en_s, flt_en_s;
      assign wr_en_s  = row_wr_ok  && (pg_sidx == SIDX_W'(s));
      assign inv_en_s = row_inv_ok && (pg_sidx == SIDX_W'(s));
      assign flt_en_s = flt_valid_i && (fl_sidx == SIDX_W'(s));

      ard_row_bank #(
         .ROWS      (ROWS_PER_SUB),
         .TAG_W     (ROW_TAG_W),
         .PICK_HIGH (SPARE_HIGH)
      ) u_bank (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .lk_tag_i     (lk_row_tag),
         .match_o      (bank_match[s]),
         .wr_row_i     (pg_ridx),
         .wr_tag_i     (pg_row_tag),
         .wr_en_i      (wr_en_s),
         .inv_en_i     (inv_en_s),
         .dup_o        (bank_dup[s]),
         .tgt_failed_o (bank_tfail[s]),
         .flt_en_i     (flt_en_s),
         .flt_row_i    (fl_ridx),
         .spare_none_o (bank_snone[s])
      );

      assign sel_d[s*ROWS_PER_SUB +: ROWS_PER_SUB] =
         {ROWS_PER_SUB{sub_match[s] & lk_valid_i}} & bank_match[s];
   end

   assign dup_sel   = bank_dup[pg_sidx];
   assign tfail_sel = bank_tfail[pg_sidx];
   assign snone_sel = bank_snone[fl_sidx];

   // Output registers.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_o             <= '0;
         hit_o             <= 1'b0;
         miss_o            <= 1'b0;
         prog_err_o        <= 1'b0;
         spare_exhausted_o <= 1'b0;
      end else begin
         sel_o      <= sel_d;
         hit_o      <= |sel_d;
         miss_o     <= lk_valid_i && ~|sel_d;
         prog_err_o <= err_d;
         if (flt_valid_i && snone_sel) spare_exhausted_o <= 1'b1;
      end
   end
endmodule

// File: rtl/assoc_row_decoder_chk.sv
`timescale 1ns/1ps
module assoc_row_decoder_chk #(
   parameter int unsigned PH_ROWS = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               lk_valid_i,
   input logic               prog_valid_i,
   input logic               flt_valid_i,
   input logic [PH_ROWS-1:0] sel_o,
   input logic               hit_o,
   input logic               miss_o,
   input logic               prog_err_o,
   input logic               spare_exhausted_o
);
   p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sel_o));

   p_hit_one_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> ($countones(sel_o) == 1));

   p_miss_no_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      miss_o |-> (sel_o == '0 && !hit_o));

   p_lookup_answer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_valid_i |=> (hit_o || miss_o));

   p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_valid_i |=> (!hit_o && !miss_o && sel_o == '0));

   p_err_needs_prog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !prog_valid_i |=> !prog_err_o);

   p_clash_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prog_valid_i && flt_valid_i) |=> prog_err_o);

   p_exhaust_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spare_exhausted_o |=> spare_exhausted_o);

   p_exhaust_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flt_valid_i |=> $stable(spare_exhausted_o));
endmodule

bind assoc_row_decoder assoc_row_decoder_chk #(.PH_ROWS(PHYS_ROWS)) u_chk (
   .clk_i             (clk_i),
   .rst_ni            (rst_ni),
   .lk_valid_i        (lk_valid_i),
   .prog_valid_i      (prog_valid_i),
   .flt_valid_i       (flt_valid_i),
   .sel_o             (sel_o),
   .hit_o             (hit_o),
   .miss_o            (miss_o),
   .prog_err_o        (prog_err_o),
   .spare_exhausted_o (spare_exhausted_o)
);

// File: tb/assoc_row_decoder_tb_top.sv
`timescale 1ns/1ps
module assoc_row_decoder_tb_top;
   localparam int PH = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [6:0]    lk_addr = '0;
   logic [PH-1:0] sel;
   logic          hit, miss, perr, exh;
   logic          pv = 1'b0;
   logic [1:0]    pop = '0;
   logic [4:0]    pphys = '0;
   logic [6:0]    paddr = '0;
   logic          fv = 1'b0;
   logic [4:0]    fphys = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   assoc_row_decoder dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .lk_valid_i(lk_valid), .lk_addr_i(lk_addr),
      .sel_o(sel), .hit_o(hit), .miss_o(miss),
      .prog_valid_i(pv), .prog_op_i(pop), .prog_phys_i(pphys), .prog_addr_i(paddr),
      .prog_err_o(perr),
      .flt_valid_i(fv), .flt_phys_i(fphys),
      .spare_exhausted_o(exh)
   );

   // kind: 0 idle, 1 lookup, 2 program, 3 fault
   typedef struct packed {
      logic [1:0] kind;
      logic [1:0] op;
      logic [4:0] phys;
      logic [6:0] addr;
      logic       ehit;
      logic       emiss;
      logic [4:0] ephys;
      logic       eerr;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VECS [NV] = '{
      '{2'd2, 2'd2, 5'd0,  7'h50, 1'b0, 1'b0, 5'd0,  1'b0, 4'd7},  // R7 sub0 <- tag5
      '{2'd2, 2'd2, 5'd8,  7'h20, 1'b0, 1'b0, 5'd0,  1'b0, 4'd7},  // R7 sub1 <- tag2
      '{2'd2, 2'd2, 5'd16, 7'h50, 1'b0, 1'b0, 5'd0,  1'b1, 4'd7},  // R7 duplicate subarray tag
      '{2'd2, 2'd0, 5'd3,  7'h09, 1'b0, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 row3 <- 9
      '{2'd2, 2'd0, 5'd5,  7'h09, 1'b0, 1'b0, 5'd0,  1'b1, 4'd5},  // R5 duplicate row tag
      '{2'd2, 2'd0, 5'd14, 7'h09, 1'b0, 1'b0, 5'd0,  1'b0, 4'd5},  // R5 same tag, other subarray ok
      '{2'd1, 2'd0, 5'd0,  7'h59, 1'b1, 1'b0, 5'd3,  1'b0, 4'd2},  // R2
      '{2'd1, 2'd0, 5'd0,  7'h29, 1'b1, 1'b0, 5'd14, 1'b0, 4'd2},  // R2
      '{2'd1, 2'd0, 5'd0,  7'h5A, 1'b0, 1'b1, 5'd0,  1'b0, 4'd3},  // R3 row tag absent
      '{2'd1, 2'd0, 5'd0,  7'h39, 1'b0, 1'b1, 5'd0,  1'b0, 4'd3},  // R3 subarray tag absent
      '{2'd2, 2'd0, 5'd3,  7'h09, 1'b0, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 rewrite own tag
      '{2'd2, 2'd0, 5'd3,  7'h0C, 1'b0, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 retag row3
      '{2'd1, 2'd0, 5'd0,  7'h5C, 1'b1, 1'b0, 5'd3,  1'b0, 4'd4},  // R4
      '{2'd1, 2'd0, 5'd0,  7'h59, 1'b0, 1'b1, 5'd0,  1'b0, 4'd4},  // R4 old tag gone
      '{2'd2, 2'd1, 5'd3,  7'h00, 1'b0, 1'b0, 5'd0,  1'b0, 4'd6},  // R6 invalidate row3
      '{2'd1, 2'd0, 5'd0,  7'h5C, 1'b0, 1'b1, 5'd0,  1'b0, 4'd6},  // R6
      '{2'd2, 2'd0, 5'd0,  7'h01, 1'b0, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 row0 <- 1
      '{2'd3, 2'd0, 5'd0,  7'h00, 1'b0, 1'b0, 5'd0,  1'b0, 4'd9},  // R9 retire row0
      '{2'd1, 2'd0, 5'd0,  7'h51, 1'b1, 1'b0, 5'd1,  1'b0, 4'd9},  // R9 moved to row1
      '{2'd2, 2'd0, 5'd0,  7'h04, 1'b0, 1'b0, 5'd0,  1'b1, 4'd5},  // R5 failed target
      '{2'd1, 2'd0, 5'd0,  7'h54, 1'b0, 1'b1, 5'd0,  1'b0, 4'd5},  // R5 not applied
      '{2'd2, 2'd3, 5'd0,  7'h00, 1'b0, 1'b0, 5'd0,  1'b0, 4'd8},  // R8 drop sub0
      '{2'd1, 2'd0, 5'd0,  7'h51, 1'b0, 1'b1, 5'd0,  1'b0, 4'd8},  // R8
      '{2'd2, 2'd2, 5'd24, 7'h50, 1'b0, 1'b0, 5'd0,  1'b0, 4'd8},  // R8 sub3 <- tag5
      '{2'd2, 2'd0, 5'd26, 7'h01, 1'b0, 1'b0, 5'd0,  1'b0, 4'd8},  // R8 row26 <- 1
      '{2'd1, 2'd0, 5'd0,  7'h51, 1'b1, 1'b0, 5'd26, 1'b0, 4'd8},  // R8 remapped subarray
      '{2'd1, 2'd0, 5'd0,  7'h29, 1'b1, 1'b0, 5'd14, 1'b0, 4'd2},  // R2 untouched
      '{2'd0, 2'd0, 5'd0,  7'h00, 1'b0, 1'b0, 5'd0,  1'b0, 4'd12}  // R12 idle
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      lk_valid = 1'b0; pv = 1'b0; fv = 1'b0;
   endtask

   task automatic check_outs(input string req, input logic eh, input logic em,
                             input logic [4:0] ep, input logic ee);
      logic [31:0] esel;
      esel = eh ? (32'd1 << ep) : 32'd0;
      chk(req, "sel", sel, esel);
      chk(req, "hit", {31'd0, hit}, {31'd0, eh});
      chk(req, "miss", {31'd0, miss}, {31'd0, em});
      chk(req, "err", {31'd0, perr}, {31'd0, ee});
   endtask

   task automatic do_lookup(input logic [6:0] a);
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic do_fault(input logic [4:0] p);
      fv = 1'b1; fphys = p;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check_outs("R1", 1'b0, 1'b0, 5'd0, 1'b0);
      chk("R1", "exhausted", {31'd0, exh}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      do_lookup(7'h50);
      check_outs("R1", 1'b0, 1'b1, 5'd0, 1'b0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = $sformatf("R%0d", VECS[i].req);
         lk_valid = (VECS[i].kind == 2'd1);
         lk_addr  = VECS[i].addr;
         pv       = (VECS[i].kind == 2'd2);
         pop      = VECS[i].op;
         pphys    = VECS[i].phys;
         paddr    = VECS[i].addr;
         fv       = (VECS[i].kind == 2'd3);
         fphys    = VECS[i].phys;
         @(negedge clk);
         idle_inputs();
         check_outs(rq, VECS[i].ehit, VECS[i].emiss, VECS[i].ephys, VECS[i].eerr);
      end

      // R11: program and fault in one cycle
      pv = 1'b1; pop = 2'b00; pphys = 5'd27; paddr = 7'h03;
      fv = 1'b1; fphys = 5'd14;
      @(negedge clk);
      idle_inputs();
      chk("R11", "err", {31'd0, perr}, 32'd1);
      do_lookup(7'h53);
      check_outs("R11", 1'b0, 1'b1, 5'd0, 1'b0);
      do_lookup(7'h29);
      check_outs("R9", 1'b1, 1'b0, 5'd8, 1'b0);

      // R10: run subarray 2 out of spares
      for (int r = 16; r < 23; r++) begin
         do_fault(5'(r));
         chk("R10", "exhausted early", {31'd0, exh}, 32'd0);
      end
      do_fault(5'd23);
      chk("R10", "exhausted", {31'd0, exh}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R10", "exhausted sticky", {31'd0, exh}, 32'd1);
      chk("R12", "hit idle", {31'd0, hit}, 32'd0);

      // R1: reset clears mapping and flags
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_outs("R1", 1'b0, 1'b0, 5'd0, 1'b0);
      chk("R1", "exhausted", {31'd0, exh}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      do_lookup(7'h29);
      check_outs("R1", 1'b0, 1'b1, 5'd0, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule